// File: doc/BRIEF.md
# Serial Character Receiver with Holding Register and Status Flags

This block receives asynchronous serial characters. Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line idles high. The receive pin passes through a two-flop synchronizer. A free-running prescaler turns the system clock into sample ticks. One bit lasts 16 ticks in normal mode and 8 ticks when the fast-rate control bit is set. A start is accepted only if the line is still low half a bit period after the falling edge. Each data bit and the stop bit are sampled one full bit period after the previous sample, which puts them at mid-bit.

A completed character moves into a one-entry holding register and sets the done flag. This happens even when the stop bit was low, and in that case the frame-error flag is also set. If a second character completes while the holding register is still unread, it is parked in the receive shift stage. It moves into the holding register when the old character is read, and the overrun flag comes up at that moment, not before. The host reads and writes through a small address-decoded register port. The interrupt request equals the done flag gated by an enable bit.

Top module: `serial_rx_unit`

## Requirements
- R1: A frame with a high stop bit loads its eight data bits into the data register (address 0) in LSB-first order and sets status bit 0 (done). One bit lasts 16 ticks, and one tick is TICK_DIV clocks.
- R2: Reading address 0 while no character is parked clears the done flag. Reading address 0 while done is clear changes no status bit.
- R3: irq_o is high exactly while control bit 0 (interrupt enable, address 2) and the done flag are both set. It stays high for as long as the data register is left unread.
- R4: A frame whose stop bit samples low still sets done, and it sets status bit 1 (frame error). The next frame with a high stop bit clears status bit 1.
- R5: When a frame completes while done is set, the holding register keeps the old character and status bit 2 (overrun) stays clear. Reading address 0 returns the old character. Right after that read, the new character is in the data register, done stays set and overrun is set.
- R6: The overrun flag stays set until the next character is transferred without overrun, and that transfer clears it.
- R7: With control bit 1 (fast rate) set, one bit lasts 8 ticks.
- R8: A low pulse shorter than half a bit period is not taken as a start bit and delivers no character.
- R9: Status bits 7 to 3 always read as zero, including bit 3 (reserved).
- R10: After reset the status and control registers read zero and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| addr_i | input | 2 | Register address: 0 data, 1 status, 2 control |
| rd_en_i | input | 1 | Read strobe; a read of address 0 consumes the character |
| wr_en_i | input | 1 | Write strobe; only address 2 is writable |
| wdata_i | input | 8 | Write data; bit 0 interrupt enable, bit 1 fast rate |
| rdata_o | output | 8 | Read data for the addressed register |
| irq_o | output | 1 | Receive interrupt request |

## Verification
A scoreboard loop checks every character delivered under interrupt service. The stream includes alternating-bit patterns, all-zero and all-one characters, and values with the MSB and LSB set, so that a wrong bit order or a bit-period error is caught. A character with a low stop bit, followed by a clean one, shows that the frame-error flag follows each frame. Repeating the stream at the fast rate separates the two bit-period settings. Directed sequences then cover a short start glitch, an interrupt left unserviced and masked, and a back-to-back pair left unread, which shows the deferred overrun and the order in which the characters come out.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HUNT
  } rx_state_e;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int TICK_DIV  = 2,
  parameter int OSR_NORM  = 16,
  parameter int OSR_FAST  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_i,
  input  logic                 fast_i,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 stop_ok_o
);
  localparam int CNT_W = $clog2(OSR_NORM);
  localparam int BIT_W = $clog2(DATA_BITS);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic tick;

  generate
    if (TICK_DIV > 1) begin : g_div
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                            div_q <= '0;
        else if (div_q == DIV_W'(TICK_DIV - 1)) div_q <= '0;
        else                                    div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DIV_W'(TICK_DIV - 1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  rx_state_e            state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [BIT_W-1:0]     idx_q;
  logic [DATA_BITS-1:0] shift_q;
  logic                 done_q, stop_q;
  logic [CNT_W-1:0]     last_cnt, half_cnt;

  assign last_cnt = fast_i ? CNT_W'(OSR_FAST - 1)     : CNT_W'(OSR_NORM - 1);
  assign half_cnt = fast_i ? CNT_W'(OSR_FAST / 2 - 1) : CNT_W'(OSR_NORM / 2 - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      done_q  <= 1'b0;
      stop_q  <= 1'b1;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        RX_IDLE: if (!rx_i) begin
          state_q <= RX_START;
          cnt_q   <= '0;
        end
        RX_START: if (tick) begin
          if (cnt_q == half_cnt) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            state_q <= rx_i ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (cnt_q == last_cnt) begin
            cnt_q   <= '0;
            shift_q <= {rx_i, shift_q[DATA_BITS-1:1]};
            if (idx_q == BIT_W'(DATA_BITS - 1)) state_q <= RX_STOP;
            else                                idx_q   <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (cnt_q == last_cnt) begin
            cnt_q   <= '0;
            done_q  <= 1'b1;
            stop_q  <= rx_i;
            // a low stop bit must see the line go high before a new start
            state_q <= rx_i ? RX_IDLE : RX_HUNT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_HUNT: if (rx_i) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign done_o    = done_q;
  assign data_o    = shift_q;
  assign stop_ok_o = stop_q;

  assert_done_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_glitch_rejected_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START && tick && cnt_q == half_cnt && rx_i) |=> state_q == RX_IDLE);
endmodule

// File: rtl/rx_hold_ctrl.sv
module rx_hold_ctrl #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 done_i,
  input  logic [DATA_BITS-1:0] frame_data_i,
  input  logic                 stop_ok_i,
  input  logic                 rd_data_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 full_o,
  output logic                 fe_o,
  output logic                 ovr_o
);
  logic [DATA_BITS-1:0] data_q, pend_data_q;
  logic                 full_q, fe_q, ovr_q, pend_q, pend_fe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q      <= '0;
      pend_data_q <= '0;
      full_q      <= 1'b0;
      fe_q        <= 1'b0;
      ovr_q       <= 1'b0;
      pend_q      <= 1'b0;
      pend_fe_q   <= 1'b0;
    end else if (rd_data_i && pend_q) begin
      // parked character surfaces, overrun becomes visible now
      data_q <= pend_data_q;
      fe_q   <= pend_fe_q;
      ovr_q  <= 1'b1;
      full_q <= 1'b1;
      pend_q <= done_i;
      if (done_i) begin
        pend_data_q <= frame_data_i;
        pend_fe_q   <= !stop_ok_i;
      end
    end else if (done_i && (!full_q || rd_data_i)) begin
      data_q <= frame_data_i;
      fe_q   <= !stop_ok_i;
      ovr_q  <= 1'b0;
      full_q <= 1'b1;
    end else if (done_i) begin
      pend_q      <= 1'b1;
      pend_data_q <= frame_data_i;
      pend_fe_q   <= !stop_ok_i;
    end else if (rd_data_i) begin
      full_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign fe_o   = fe_q;
  assign ovr_o  = ovr_q;

  assert_load_sets_done_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !full_q && !pend_q) |=> full_q && data_q == $past(frame_data_i));

  assert_read_clears_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && full_q && !pend_q && !done_i) |=> !full_q);

  assert_fe_follows_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !full_q && !pend_q) |=> fe_q == !$past(stop_ok_i));

  assert_hold_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !rd_data_i) |=> $stable(data_q));

  assert_ovr_deferred_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_i && pend_q) |=> ovr_q && full_q);

  assert_ovr_cleared_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !full_q && !pend_q) |=> !ovr_q);
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import serial_rx_pkg::*;
#(
  parameter int TICK_DIV    = 2,
  parameter int OSR_NORM    = 16,
  parameter int OSR_FAST    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic [1:0] addr_i,
  input  logic       rd_en_i,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  localparam int DATA_BITS = 8;

  logic                 rx_s, done, stop_ok, rd_data;
  logic [DATA_BITS-1:0] frame_data, hold_data;
  logic                 full, fe, ovr;
  logic                 irq_en_q, fast_q;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  rx_bit_engine #(
    .DATA_BITS(DATA_BITS),
    .TICK_DIV (TICK_DIV),
    .OSR_NORM (OSR_NORM),
    .OSR_FAST (OSR_FAST)
  ) u_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_i     (rx_s),
    .fast_i   (fast_q),
    .done_o   (done),
    .data_o   (frame_data),
    .stop_ok_o(stop_ok)
  );

  assign rd_data = rd_en_i && (addr_i == ADDR_DATA);

  rx_hold_ctrl #(.DATA_BITS(DATA_BITS)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done),
    .frame_data_i(frame_data),
    .stop_ok_i   (stop_ok),
    .rd_data_i   (rd_data),
    .data_o      (hold_data),
    .full_o      (full),
    .fe_o        (fe),
    .ovr_o       (ovr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q <= 1'b0;
      fast_q   <= 1'b0;
    end else if (wr_en_i && addr_i == ADDR_CTRL) begin
      irq_en_q <= wdata_i[0];
      fast_q   <= wdata_i[1];
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_DATA: rdata_o = hold_data;
      ADDR_STAT: rdata_o = {4'b0, 1'b0, ovr, fe, full}; // bit 3 reserved
      ADDR_CTRL: rdata_o = {6'b0, fast_q, irq_en_q};
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = irq_en_q && full;

  assert_irq_masked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_q |-> !irq_o);
endmodule

// File: tb/serial_rx_unit_bench.sv
module serial_rx_unit_bench;
  localparam int TICK_DIV = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b1;
  logic [1:0] addr_i = 2'd0;
  logic       rd_en_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       irq_o;

  always #2 clk = ~clk;

  serial_rx_unit #(.TICK_DIV(TICK_DIV)) u_serial_rx_unit (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .addr_i (addr_i),
    .rd_en_i(rd_en_i),
    .wr_en_i(wr_en_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .irq_o  (irq_o)
  );

  int         checks = 0;
  int         fails = 0;
  logic [8:0] exp_q[$];
  bit         mon_en = 1'b0;
  bit         fast_mode = 1'b0;
  string      mon_tag = "R1";

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr_i  = a;
    rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i  = a;
    wdata_i = d;
    wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] d, input bit stop, input bit push);
    int bit_clks;
    bit_clks = (fast_mode ? 8 : 16) * TICK_DIV;
    if (push) exp_q.push_back({~stop, d});
    @(negedge clk);
    rx_i = 1'b0;
    repeat (bit_clks) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_i = d[i];
      repeat (bit_clks) @(negedge clk);
    end
    rx_i = stop;
    repeat (bit_clks) @(negedge clk);
    rx_i = 1'b1;
    repeat (2 * bit_clks) @(negedge clk);
  endtask

  // scoreboard monitor: services the interrupt and compares against the queue
  initial begin
    logic [7:0] s, d;
    logic [8:0] e;
    forever begin
      @(negedge clk);
      if (mon_en && irq_o) begin
        host_read(2'd1, s);
        host_read(2'd0, d);
        if (exp_q.size() == 0) begin
          chk({mon_tag, " unexpected character"}, 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk({mon_tag, " data"}, d, e[7:0]);
          chk("R4 frame error flag", s[1], e[8]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish_test();
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;

    host_read(2'd1, r); chk("R10 status after reset", r, 8'h00);
    host_read(2'd2, r); chk("R10 control after reset", r, 8'h00);
    chk("R10 irq after reset", irq_o, 0);

    // scoreboard stream, normal rate
    host_write(2'd2, 8'h01);
    mon_en = 1'b1;
    send_frame(8'hA5, 1'b1, 1'b1);
    send_frame(8'h3C, 1'b1, 1'b1);
    send_frame(8'hFF, 1'b1, 1'b1);
    send_frame(8'h00, 1'b1, 1'b1);
    send_frame(8'h81, 1'b1, 1'b1);
    send_frame(8'h5A, 1'b0, 1'b1); // low stop bit, R4
    send_frame(8'hC3, 1'b1, 1'b1); // clears frame error, R4
    wait (exp_q.size() == 0);
    repeat (10) @(negedge clk);
    mon_en = 1'b0;

    // fast rate, R7
    host_write(2'd2, 8'h03);
    host_read(2'd2, r); chk("R7 control readback", r, 8'h03);
    fast_mode = 1'b1;
    mon_tag   = "R7";
    mon_en    = 1'b1;
    send_frame(8'h96, 1'b1, 1'b1);
    send_frame(8'h17, 1'b1, 1'b1);
    send_frame(8'hE8, 1'b1, 1'b1);
    wait (exp_q.size() == 0);
    repeat (10) @(negedge clk);
    mon_en    = 1'b0;
    fast_mode = 1'b0;
    host_write(2'd2, 8'h01);

    // R8: short start glitch
    @(negedge clk);
    rx_i = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rx_i = 1'b1;
    repeat (64 * TICK_DIV) @(negedge clk);
    host_read(2'd1, r); chk("R8 glitch gives no character", r, 8'h00);

    // R3: interrupt held while unread, masked by enable
    send_frame(8'h42, 1'b1, 1'b0);
    chk("R3 irq raised", irq_o, 1);
    repeat (40) @(negedge clk);
    chk("R3 irq held while unread", irq_o, 1);
    host_write(2'd2, 8'h00);
    chk("R3 irq masked", irq_o, 0);
    host_write(2'd2, 8'h01);
    chk("R3 irq unmasked", irq_o, 1);
    host_read(2'd0, r); chk("R1 data after glitch", r, 8'h42);
    host_read(2'd1, r); chk("R2 done cleared by read", r, 8'h00);
    chk("R3 irq drops after read", irq_o, 0);
    host_read(2'd0, r);
    host_read(2'd1, r); chk("R2 read of empty register", r, 8'h00);

    // R5: deferred overrun
    send_frame(8'h11, 1'b1, 1'b0);
    send_frame(8'h22, 1'b1, 1'b0);
    host_read(2'd1, r); chk("R5 overrun hidden before read", r, 8'h01);
    host_read(2'd0, r); chk("R5 old character first", r, 8'h11);
    host_read(2'd1, r); chk("R5 overrun shown after read", r, 8'h05);
    chk("R9 upper status bits zero", r[7:3], 0);
    host_read(2'd0, r); chk("R5 parked character second", r, 8'h22);
    host_read(2'd1, r); chk("R6 overrun persists", r, 8'h04);
    send_frame(8'h33, 1'b1, 1'b0);
    host_read(2'd1, r); chk("R6 overrun cleared by clean transfer", r, 8'h01);
    host_read(2'd0, r); chk("R1 data after overrun", r, 8'h33);

    // R9 with frame error set
    send_frame(8'h7E, 1'b0, 1'b0);
    host_read(2'd1, r); chk("R9 reserved bit with error set", r, 8'h03);
    host_read(2'd0, r); chk("R4 data of errored frame", r, 8'h7E);

    repeat (20) @(negedge clk);
    finish_test();
  end
endmodule